// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two lowest address bits of a four-beat memory burst. A load pulse captures a starting two-bit address together with an ordering mode. Each later advance pulse moves the output to the next address of the burst. After the fourth address, the next advance returns the output to the starting address. The upper address bits are handled outside the block.

Two orderings are available. In interleaved order, the output is the starting address XORed with a beat count of 0, 1, 2 and 3. In linear order, the output is the starting address plus the beat count, taken modulo 4. A flag marks the fourth address of the burst so that the surrounding control logic knows when the burst is complete.

Top module: `burst_seq`

## Requirements
- R1: A cycle with `rst_n` low sets `addr_o` to 00 and `last_o` to 0 after the next rising edge. This happens even in the middle of a burst.
- R2: A cycle with `load_i` high makes `addr_o` equal to `start_i` and `last_o` equal to 0 after the rising edge.
- R3: With the captured mode at 1 (interleaved), the three advances after a load give `start ^ 01`, `start ^ 10` and `start ^ 11`. For a start of 01, the sequence is 01, 00, 11, 10.
- R4: With the captured mode at 0 (linear), each advance adds one to `addr_o` modulo 4. For a start of 10, the sequence is 10, 11, 00, 01.
- R5: A cycle with both `load_i` and `adv_i` low leaves `addr_o` and `last_o` unchanged.
- R6: `last_o` is 1 exactly while `addr_o` shows the fourth address of the burst, which is beat count 3.
- R7: An advance taken while `last_o` is 1 returns `addr_o` to the starting address and clears `last_o`.
- R8: When `load_i` and `adv_i` are both high in the same cycle, the load wins. `addr_o` becomes `start_i` and the beat count restarts at 0.
- R9: `mode_i` is captured only on a load, and reset clears the captured mode to 0. Changes to `mode_i` between loads do not alter the ordering of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Starts a new burst from `start_i` |
| start_i | input | 2 | Starting low address bits |
| adv_i | input | 1 | Steps to the next burst address |
| mode_i | input | 1 | Ordering, captured on load: 1 interleaved, 0 linear |
| addr_o | output | 2 | Current low address bits |
| last_o | output | 1 | High on the fourth address of the burst |

## Verification
Every starting address is run through a full burst in both modes. Starts of 01 and 11 are where XOR and addition give different sequences, so only they show whether the mode really selects the ordering. Starts of 00 and 10 give the same sequence in both modes, so they isolate the beat counting and the flag on the fourth address. Directed cases then cover several situations:
- an advance past the fourth beat;
- idle cycles;
- a load and an advance arriving together;
- `mode_i` toggled in the middle of a burst that starts at 01, where the two orderings differ on the very next beat;
- reset applied in the middle of a burst.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [BEAT_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = '1;
  localparam logic [BEAT_W-1:0] ONE       = BEAT_W'(1);

  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic              xor_mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= '0;
      beat_q     <= '0;
      xor_mode_q <= 1'b0;
    end else if (load_i) begin
      start_q    <= start_i;
      beat_q     <= '0;
      xor_mode_q <= mode_i;
    end else if (adv_i) begin
      beat_q     <= beat_q + ONE;
    end
  end

  assign addr_o = xor_mode_q ? (start_q ^ beat_q) : (start_q + beat_q);
  assign last_o = (beat_q == LAST_BEAT);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (addr_o == '0) && !last_o); // R1
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(start_i)) && !last_o); // R2
  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && xor_mode_q && !last_o) |=>
      ((addr_o ^ $past(addr_o)) == ($past(beat_q) ^ ($past(beat_q) + ONE)))); // R3
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && !xor_mode_q) |=> (addr_o == $past(addr_o) + ONE)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(last_o))); // R5
  AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && last_o) |=> (addr_o == start_q) && !last_o); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(xor_mode_q)); // R9
endmodule

// File: tb/burst_seq_tb_top.sv
`timescale 1ns/1ps
module burst_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i;
  logic [1:0] start_i;
  logic       adv_i;
  logic       mode_i;
  logic [1:0] addr_o;
  logic       last_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
    .adv_i(adv_i), .mode_i(mode_i), .addr_o(addr_o), .last_o(last_o)
  );

  // {mode, start, first, second, third, fourth}
  localparam logic [10:0] VECS [8] = '{
    11'b1_00_00_01_10_11,
    11'b1_01_01_00_11_10,
    11'b1_10_10_11_00_01,
    11'b1_11_11_10_01_00,
    11'b0_00_00_01_10_11,
    11'b0_01_01_10_11_00,
    11'b0_10_10_11_00_01,
    11'b0_11_11_00_01_10
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic rst, input logic ld, input logic [1:0] st,
                     input logic adv, input logic md);
    rst_n = rst; load_i = ld; start_i = st; adv_i = adv; mode_i = md;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    check("R1 reset state", {last_o, addr_o}, 3'b000);

    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b1, VECS[i][9:8], 1'b0, VECS[i][10]);
      check("R2 load start", {last_o, addr_o}, {1'b0, VECS[i][7:6]});
      for (int b = 1; b < 4; b++) begin
        cyc(1'b1, 1'b0, 2'b00, 1'b1, ~VECS[i][10]);
        check(VECS[i][10] ? "R3 interleaved step" : "R4 linear step",
              {1'b0, addr_o}, {1'b0, VECS[i][7-2*b -: 2]});
        check("R6 last flag", {2'b00, last_o}, {2'b00, b == 3});
      end
    end

    // After mode 0 start 11: fourth address 10, so wrap goes back to 11
    cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
    check("R7 wrap to start", {last_o, addr_o}, 3'b011);
    cyc(1'b1, 1'b0, 2'b01, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    check("R5 idle hold", {last_o, addr_o}, 3'b011);

    cyc(1'b1, 1'b1, 2'b10, 1'b1, 1'b1);
    check("R8 load over advance", {last_o, addr_o}, 3'b010);
    cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b1);
    check("R8 beat restarted", {last_o, addr_o}, 3'b011);

    cyc(1'b1, 1'b1, 2'b01, 1'b1, 1'b1);
    check("R9 load interleaved", {last_o, addr_o}, 3'b001);
    cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
    check("R9 mode held midburst", {last_o, addr_o}, 3'b000);
    cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
    check("R9 mode held beat2", {last_o, addr_o}, 3'b011);
    cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
    check("R6 fourth beat", {last_o, addr_o}, 3'b110);

    cyc(1'b0, 1'b0, 2'b11, 1'b1, 1'b1);
    check("R1 midburst reset", {last_o, addr_o}, 3'b000);
    cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b1);
    check("R1 post reset step", {last_o, addr_o}, 3'b001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule